// File: doc/BRIEF.md
# CRC-32 Parallel Folding Accumulator

This block reduces a message, delivered as a stream of 128-bit beats, to one 128-bit residue. The residue is congruent to the message modulo the CRC-32 generator polynomial 0x04C11DB7, with bits taken most significant first. A downstream reducer then turns it into the final 32-bit checksum. The initial CRC value is folded in by XOR-ing it into the top 32 bits of the first beat.

The first four beats fill four independent 128-bit lanes. Each later group of four beats advances every lane by 512 bits in a single cycle. The step is a carry-less multiply of the lane's upper half by one stride constant and of its lower half by another, XOR-ed with the matching new beat. Beats of an incomplete group are held in a staging buffer. When the last beat arrives, the lanes are merged into lane 0 in order 1, 2, 3 using a 128-bit stride constant pair. The staged beats are then folded in one per cycle, and a done pulse presents the residue. While merging, the block drops `ready_o` to stall the source.

Top module: `crc_fold_acc`

## Requirements
- R1: After reset, `ready_o` is 1 and `done_o` and `err_o` are 0.
- R2: For a message of N full beats (N >= 4) and initial value C, the residue R satisfies R mod P = (M + C·x^(128N-32)) mod P, where M is the message as a polynomial with the first beat's bit 127 as the highest term and P = 0x104C11DB7. Equivalently, a bitwise MSB-first CRC of R with start value 0 equals a bitwise MSB-first CRC of the message with start value C.
- R3: Messages that span several whole 64-byte groups give a residue meeting R2. Each group advances all four lanes with the 512-bit stride constants.
- R4: Messages whose length is not a multiple of four beats give a residue meeting R2. The one to three trailing beats are folded after the lane merge, in arrival order.
- R5: `done_o` is a one-cycle pulse. It is high in the cycle after rising edge E+3+T, where E is the edge that accepted the last beat and T = N mod 4.
- R6: `ready_o` is 0 from the edge accepting the last beat until the done pulse ends, and 1 again in the cycle after `done_o`. Beats offered while `ready_o` is 0 do not change the residue.
- R7: While idle, a beat with `valid_i` high but `start_i` low is ignored and raises neither `err_o` nor `done_o`.
- R8: If the last beat has `nbytes_i` other than 16, `err_o` pulses for one cycle after that edge, no done pulse follows, and the block is ready again.
- R9: If the last beat is accepted before four beats have arrived, `err_o` pulses for one cycle and no done pulse follows.
- R10: `done_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Marks the first beat of a message |
| valid_i | input | 1 | Beat present on `data_i` |
| last_i | input | 1 | Beat is the final one of the message |
| nbytes_i | input | 5 | Valid bytes in the beat (16 = full), examined on the last beat |
| data_i | input | 128 | Message beat, bit 127 first in polynomial order |
| crc_init_i | input | 32 | Initial CRC value, sampled with the first beat |
| ready_o | output | 1 | Block accepts a beat this cycle |
| done_o | output | 1 | One-cycle pulse: `residue_o` holds the result |
| err_o | output | 1 | One-cycle pulse: message rejected |
| residue_o | output | 128 | Folded 128-bit residue |

## Verification
Two events can land in the same cycle: the fourth beat of a group, which fires the 512-bit lane fold, and the last-beat flag, which starts the merge. The bench provokes this with lengths of 4 and 8 beats and with random lengths that happen to be multiples of four. It judges the case by the residue against a bitwise CRC model and by the done latency with T = 0. It also stalls the source with random bubbles and drives garbage beats, some flagged as first, while `ready_o` is low. The residue must still match and no spurious message may start.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RUN   = 3'd1,
      ST_MERGE = 3'd2,
      ST_TAIL  = 3'd3,
      ST_DONE  = 3'd4
   } fold_state_e;
endpackage

// File: rtl/crc_clmul.sv
// Combinational carry-less (GF(2)) multiplier.
module crc_clmul #(
   parameter int unsigned A_W = 64,
   parameter int unsigned B_W = 32,
   localparam int unsigned P_W = A_W + B_W - 1
) (
   input  logic [A_W-1:0] a_i,
   input  logic [B_W-1:0] b_i,
   output logic [P_W-1:0] p_o
);
   generate
      if (A_W < 1 || B_W < 1) begin : g_bad_width
         $error("crc_clmul: operand widths must be positive");
      end
   endgenerate

   logic [P_W-1:0] part [B_W];

   for (genvar i = 0; i < B_W; i++) begin : g_part
      assign part[i] = b_i[i] ? ({{(B_W-1){1'b0}}, a_i} << i) : '0;
   end

   always_comb begin
      p_o = '0;
      for (int i = 0; i < B_W; i++) begin
         p_o = p_o ^ part[i];
      end
   end
endmodule

// File: rtl/crc_fold_step.sv
// One fold: (hi * K_HI) ^ (lo * K_LO) ^ addend.
module crc_fold_step #(
   parameter int unsigned          BEAT_W  = 128,
   parameter int unsigned          CONST_W = 32,
   parameter logic [CONST_W-1:0]   K_HI    = '0,
   parameter logic [CONST_W-1:0]   K_LO    = '0,
   localparam int unsigned         HALF_W  = BEAT_W / 2,
   localparam int unsigned         PROD_W  = HALF_W + CONST_W - 1
) (
   input  logic [BEAT_W-1:0] vec_i,
   input  logic [BEAT_W-1:0] add_i,
   output logic [BEAT_W-1:0] fold_o
);
   generate
      if (PROD_W > BEAT_W) begin : g_bad_prod
         $error("crc_fold_step: product wider than beat");
      end
   endgenerate

   logic [PROD_W-1:0] prod_hi;
   logic [PROD_W-1:0] prod_lo;

   crc_clmul #(.A_W(HALF_W), .B_W(CONST_W)) u_mul_hi (
      .a_i (vec_i[BEAT_W-1:HALF_W]),
      .b_i (K_HI),
      .p_o (prod_hi)
   );

   crc_clmul #(.A_W(HALF_W), .B_W(CONST_W)) u_mul_lo (
      .a_i (vec_i[HALF_W-1:0]),
      .b_i (K_LO),
      .p_o (prod_lo)
   );

   generate
      if (PROD_W == BEAT_W) begin : g_full
         assign fold_o = (prod_hi ^ prod_lo) ^ add_i;
      end else begin : g_ext
         assign fold_o = {{(BEAT_W-PROD_W){1'b0}}, prod_hi ^ prod_lo} ^ add_i;
      end
   endgenerate
endmodule

// File: rtl/crc_fold_acc.sv
// Four-lane CRC-32 folding accumulator producing a 128-bit residue.
module crc_fold_acc
   import crc_fold_pkg::*;
#(
   parameter int unsigned        LANES   = 4,
   parameter int unsigned        BEAT_W  = 128,
   parameter int unsigned        CRC_W   = 32,
   parameter logic [CRC_W-1:0]   K_STR_HI = 32'h8833794C,
   parameter logic [CRC_W-1:0]   K_STR_LO = 32'hE6228B11,
   parameter logic [CRC_W-1:0]   K_MRG_HI = 32'hC5B9CD4C,
   parameter logic [CRC_W-1:0]   K_MRG_LO = 32'hE8A45605,
   localparam int unsigned       BEAT_BYTES = BEAT_W / 8,
   localparam int unsigned       NB_W       = $clog2(BEAT_BYTES + 1),
   localparam int unsigned       IDX_W      = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              valid_i,
   input  logic              last_i,
   input  logic [NB_W-1:0]   nbytes_i,
   input  logic [BEAT_W-1:0] data_i,
   input  logic [CRC_W-1:0]  crc_init_i,
   output logic              ready_o,
   output logic              done_o,
   output logic              err_o,
   output logic [BEAT_W-1:0] residue_o
);
   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("crc_fold_acc: LANES must be a power of two, at least 2");
      end
      if (BEAT_W % 16 != 0 || CRC_W > BEAT_W / 2) begin : g_bad_beat
         $error("crc_fold_acc: beat width incompatible with CRC width");
      end
   endgenerate

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LANES - 1);
   localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

   fold_state_e       state_q;
   logic [BEAT_W-1:0] lane_q   [LANES];
   logic [BEAT_W-1:0] stage_q  [LANES-1];
   logic [BEAT_W-1:0] stride_fold [LANES];
   logic [BEAT_W-1:0] merge_add;
   logic [BEAT_W-1:0] merge_fold;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  mcnt_q;
   logic [IDX_W-1:0]  tail_n_q;
   logic [IDX_W-1:0]  tcnt_q;
   logic              primed_q;
   logic              err_q;
   logic              take;
   logic              bad_last;

   // 512-bit stride fold, one engine per lane; the final lane's addend is
   // the live beat, the others come from the staging buffer.
   for (genvar l = 0; l < LANES; l++) begin : g_stride
      logic [BEAT_W-1:0] add_l;
      if (l == LANES - 1) begin : g_live
         assign add_l = data_i;
      end else begin : g_staged
         assign add_l = stage_q[l];
      end
      crc_fold_step #(
         .BEAT_W (BEAT_W), .CONST_W (CRC_W),
         .K_HI (K_STR_HI), .K_LO (K_STR_LO)
      ) u_step (
         .vec_i  (lane_q[l]),
         .add_i  (add_l),
         .fold_o (stride_fold[l])
      );
   end

   // 128-bit merge/tail fold shared by both finishing phases.
   assign merge_add = (state_q == ST_MERGE) ? lane_q[mcnt_q] : stage_q[tcnt_q];

   crc_fold_step #(
      .BEAT_W (BEAT_W), .CONST_W (CRC_W),
      .K_HI (K_MRG_HI), .K_LO (K_MRG_LO)
   ) u_merge (
      .vec_i  (lane_q[0]),
      .add_i  (merge_add),
      .fold_o (merge_fold)
   );

   assign take     = valid_i && (state_q == ST_RUN);
   assign bad_last = (nbytes_i != NB_W'(BEAT_BYTES)) || (!primed_q && idx_q != IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         mcnt_q   <= '0;
         tail_n_q <= '0;
         tcnt_q   <= '0;
         primed_q <= 1'b0;
         err_q    <= 1'b0;
         for (int l = 0; l < LANES; l++) lane_q[l] <= '0;
         for (int l = 0; l < LANES - 1; l++) stage_q[l] <= '0;
      end else begin
         err_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (valid_i && start_i) begin
                  lane_q[0] <= data_i ^ {crc_init_i, {(BEAT_W-CRC_W){1'b0}}};
                  idx_q     <= IDX_ONE;
                  primed_q  <= 1'b0;
                  if (last_i) begin
                     err_q <= 1'b1;
                  end else begin
                     state_q <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (take) begin
                  if (!primed_q) begin
                     lane_q[idx_q] <= data_i;
                     if (idx_q == IDX_LAST) primed_q <= 1'b1;
                  end else if (idx_q == IDX_LAST) begin
                     for (int l = 0; l < LANES; l++) lane_q[l] <= stride_fold[l];
                  end else begin
                     stage_q[idx_q] <= data_i;
                  end
                  idx_q <= idx_q + IDX_ONE;
                  if (last_i) begin
                     if (bad_last) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                     end else begin
                        tail_n_q <= idx_q + IDX_ONE;
                        mcnt_q   <= IDX_ONE;
                        state_q  <= ST_MERGE;
                     end
                  end
               end
            end
            ST_MERGE: begin
               lane_q[0] <= merge_fold;
               mcnt_q    <= mcnt_q + IDX_ONE;
               tcnt_q    <= '0;
               if (mcnt_q == IDX_LAST) begin
                  state_q <= (tail_n_q == '0) ? ST_DONE : ST_TAIL;
               end
            end
            ST_TAIL: begin
               lane_q[0] <= merge_fold;
               tcnt_q    <= tcnt_q + IDX_ONE;
               if (tcnt_q == tail_n_q - IDX_ONE) state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_RUN);
   assign done_o    = (state_q == ST_DONE);
   assign err_o     = err_q;
   assign residue_o = lane_q[0];
endmodule

// File: rtl/crc_fold_acc_chk.sv
module crc_fold_acc_chk
   import crc_fold_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        valid_i,
   input logic        last_i,
   input logic        ready_o,
   input logic        done_o,
   input logic        err_o,
   input fold_state_e state_i
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o); // R8
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R10
   AST_LAST_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_RUN && valid_i && last_i) |=> (err_o || !ready_o)); // R6
   AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !ready_o); // R6
   AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> ready_o); // R6
   AST_ERR_READY: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ready_o); // R8
endmodule

bind crc_fold_acc crc_fold_acc_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .valid_i (valid_i),
   .last_i  (last_i),
   .ready_o (ready_o),
   .done_o  (done_o),
   .err_o   (err_o),
   .state_i (state_q)
);

// File: tb/tb_crc_fold_acc.sv
`timescale 1ns/1ps
module tb_crc_fold_acc;
   localparam logic [31:0] POLY = 32'h04C11DB7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         valid_i = 1'b0;
   logic         last_i = 1'b0;
   logic [4:0]   nbytes_i = 5'd16;
   logic [127:0] data_i = '0;
   logic [31:0]  crc_init_i = '0;
   logic         ready_o, done_o, err_o;
   logic [127:0] residue_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;
   logic [127:0] msg [16];

   always #2.5 clk = ~clk;

   crc_fold_acc dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .valid_i (valid_i),
      .last_i (last_i), .nbytes_i (nbytes_i), .data_i (data_i),
      .crc_init_i (crc_init_i), .ready_o (ready_o), .done_o (done_o),
      .err_o (err_o), .residue_o (residue_o)
   );

   function automatic logic [31:0] crc_bits(input logic [31:0] init, input logic [127:0] beat);
      logic [31:0] c = init;
      for (int i = 127; i >= 0; i--) begin
         logic fb = c[31] ^ beat[i];
         c = {c[30:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      return c;
   endfunction

   function automatic logic [31:0] crc_msg(input logic [31:0] init, input int n);
      logic [31:0] c = init;
      for (int b = 0; b < n; b++) c = crc_bits(c, msg[b]);
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic junk_beat(input bit en);
      valid_i  = en;
      start_i  = en ? 1'($urandom) : 1'b0;
      last_i   = en ? 1'($urandom) : 1'b0;
      data_i   = {$urandom, $urandom, $urandom, $urandom};
      nbytes_i = 5'd16;
   endtask

   // Sends a message of n full beats and checks residue, latency and handshake.
   task automatic run_msg(input int n, input logic [31:0] c, input bit gaps,
                          input bit junk, input string req);
      int k;
      int t;
      logic [31:0] exp_crc;
      for (int b = 0; b < n; b++) msg[b] = {$urandom, $urandom, $urandom, $urandom};
      for (int b = 0; b < n; b++) begin
         if (gaps && ($urandom % 3 == 0)) begin
            valid_i = 1'b0;
            @(posedge clk); @(negedge clk);
         end
         valid_i = 1'b1; start_i = (b == 0); last_i = (b == n - 1);
         nbytes_i = 5'd16; data_i = msg[b]; crc_init_i = c;
         @(posedge clk);
         @(negedge clk);
      end
      junk_beat(junk);
      k = 0;
      t = n % 4;
      while (!done_o && k < 20) begin
         check(!err_o, "R10", "no error during message", 128'(err_o), 128'd0);
         check(!ready_o, "R6", "ready low while finishing", 128'(ready_o), 128'd0);
         @(posedge clk); k++;
         @(negedge clk);
         if (!done_o) junk_beat(junk);
      end
      junk_beat(1'b0);
      check(k == 3 + t, "R5", "done latency", 128'(k), 128'(3 + t));
      exp_crc = crc_msg(c, n);
      check(crc_bits(32'd0, residue_o) == exp_crc, req, "residue congruence",
            128'(crc_bits(32'd0, residue_o)), 128'(exp_crc));
      check(!err_o, "R10", "done without error", 128'(err_o), 128'd0);
      @(posedge clk); @(negedge clk);
      check(!done_o, "R5", "done lasts one cycle", 128'(done_o), 128'd0);
      check(ready_o, "R6", "ready after done", 128'(ready_o), 128'd1);
   endtask

   task automatic run_bad(input int n, input logic [4:0] nb, input string req);
      for (int b = 0; b < n; b++) begin
         valid_i = 1'b1; start_i = (b == 0); last_i = (b == n - 1);
         nbytes_i = (b == n - 1) ? nb : 5'd16;
         data_i = {$urandom, $urandom, $urandom, $urandom};
         crc_init_i = $urandom;
         @(posedge clk);
         @(negedge clk);
      end
      junk_beat(1'b0);
      check(err_o, req, "error pulse", 128'(err_o), 128'd1);
      check(!done_o, req, "no done on error", 128'(done_o), 128'd0);
      for (int i = 0; i < 6; i++) begin
         @(posedge clk); @(negedge clk);
         check(!err_o && !done_o && ready_o, req, "idle after error",
               {125'd0, err_o, done_o, ready_o}, 128'd1);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_C0DE));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(ready_o && !done_o && !err_o, "R1", "reset outputs",
            {125'd0, ready_o, done_o, err_o}, 128'b100);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check(ready_o && !done_o && !err_o, "R1", "after reset release",
            {125'd0, ready_o, done_o, err_o}, 128'b100);

      // R2: minimal message, fourth-beat fill coincides with last
      run_msg(4, 32'hFFFF_FFFF, 0, 0, "R2");
      run_msg(4, 32'h0000_0000, 0, 0, "R2");
      // R3: two and three full groups, stride fold meets last
      run_msg(8, 32'h1234_5678, 0, 0, "R3");
      run_msg(12, 32'hFFFF_FFFF, 1, 1, "R3");
      // R4: trailing beats after the lanes
      run_msg(5, 32'hDEAD_BEEF, 0, 0, "R4");
      run_msg(7, 32'hFFFF_FFFF, 0, 1, "R4");
      run_msg(10, 32'hA5A5_5A5A, 1, 0, "R4");

      // R7: stray beats while idle
      for (int i = 0; i < 4; i++) begin
         valid_i = 1'b1; start_i = 1'b0; last_i = 1'b1; nbytes_i = 5'd3;
         data_i = {$urandom, $urandom, $urandom, $urandom};
         @(posedge clk); @(negedge clk);
         check(!err_o && !done_o && ready_o, "R7", "idle beat ignored",
               {125'd0, err_o, done_o, ready_o}, 128'd1);
      end
      junk_beat(1'b0);
      run_msg(6, 32'h0F0F_0F0F, 0, 0, "R7");

      // R8, R9: rejected messages
      run_bad(5, 5'd9, "R8");
      run_bad(4, 5'd0, "R8");
      run_bad(2, 5'd16, "R9");
      run_bad(1, 5'd16, "R9");
      run_msg(4, 32'hCAFE_F00D, 0, 0, "R2");

      // Random messages with bubbles and busy-time garbage (R6)
      for (int m = 0; m < 24; m++) begin
         run_msg(4 + int'($urandom % 9), $urandom, 1'($urandom), 1'($urandom),
                 (m % 2 == 0) ? "R6" : "R2");
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule